// File: doc/BRIEF.md
# Scanline Window Transfer Sequencer

This block turns a rectangular window inside a larger, line-padded frame in external memory into a stream of transfer commands. It walks the window one line at a time. Each line is split into fixed-size page transfers. Every command carries three things: the memory address, a length in bursts, and the index of the four-page channel buffer the data belongs to. The full page size is 2^XFER_BITS bursts, and only the final transfer of a line may be shorter.

Software sets up the block through a small register port. It programs:
- the frame base address,
- the line pitch,
- the window size and origin,
- a start position inside the window,
- a mode word.

A frame-start strobe launches a frame. A downstream requester accepts each command with an acknowledge. The consumer hands buffer pages back with a page-release strobe, and that strobe paces the block. A status word reports a page count, busy and frame-done.

Top module: `scl_seq`

## Requirements
- R1: After reset, `xfer_req` is low and `status` reads 0.
- R2: Each transfer address is `(base + (Y0 + y) * pitch + X0 + x) mod 2^ADDR_BITS`. Here x and y are the position inside the window, in 16-byte units and lines.
- R3: A window line of width W starts at x, and x steps by the page size P = 2^XFER_BITS. Every transfer has length P, except the last one of a line, which carries `W - x` (between 1 and P).
- R4: A width field of 0 (register select 3, bits 13:0) means a width of 16384 units.
- R5: A height field of 0 (register select 3, bits 31:16) means 65536 lines, so the frame is still busy after hundreds of lines.
- R6: The first line is line `sy`, and it starts at `x = sx` (register select 5: sx in bits 12:0, sy in bits 31:16). Every later line starts at x = 0. The origin X0/Y0 is register select 4, with X0 in bits 12:0 and Y0 in bits 31:16.
- R7: `xfer_page` is 0 for the first transfer of a frame and advances by one modulo 4 with each accepted transfer.
- R8: The mode word (register select 0) holds `not_reset` in bit 0, `enable` in bit 1 and `extra` in bits 3:2. No new request is made while the number of issued-but-unreleased pages equals `4 - min(extra, 2)`. Each `page_release` then permits one more.
- R9: `status` bits 19:16 hold the number of accepted transfers of the current frame modulo 16. Bit 24 is busy and bit 25 is frame-done. All other bits are 0.
- R10: Frame-done rises with the acceptance of the last transfer of the last line, together with busy falling. It stays set until the next accepted frame start, which clears it.
- R11: Writing `not_reset = 0` cancels the frame at once: requests stop and `status` returns to 0.
- R12: While `enable` is 0, `frame_start` is ignored and no request is raised. Clearing it mid-frame pauses the walk, and setting it again resumes the walk at the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 mode, 1 base, 2 pitch, 3 size, 4 origin, 5 start |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Launch a frame (honoured only with enable and not_reset set) |
| page_release | input | 1 | Consumer returns one buffer page |
| xfer_req | output | 1 | A transfer command is valid |
| xfer_ack | input | 1 | Command accepted in this cycle |
| xfer_addr | output | ADDR_BITS | Transfer start address in 16-byte units |
| xfer_len | output | XFER_BITS+1 | Transfer length in bursts (1..2^XFER_BITS) |
| xfer_page | output | 2 | Channel buffer page for this transfer |
| status | output | 32 | Page count, busy and frame-done |

## Verification
The bench builds the block with XFER_BITS = 2 and leaves every other parameter at its default. Pages are then four bursts wide, so a sweep over window widths 1 to 9 and heights 1 to 3 reaches:
- lines of one page, lines of several pages and lines with a short tail;
- first-line start offsets;
- wrap of the buffer page index.

The same small page size makes a zero-width window (16384 units, 4096 transfers) cheap enough to run in full, together with an address wrap and every setting of the reserved-page count.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // register selects
  localparam logic [2:0] SEL_MODE   = 3'd0;
  localparam logic [2:0] SEL_BASE   = 3'd1;
  localparam logic [2:0] SEL_PITCH  = 3'd2;
  localparam logic [2:0] SEL_SIZE   = 3'd3;
  localparam logic [2:0] SEL_ORIGIN = 3'd4;
  localparam logic [2:0] SEL_START  = 3'd5;

  // mode word: bit 0 live (not in reset), bit 1 run (enable), bits 3:2 reserved pages
  typedef struct packed {
    logic [1:0] spare_pg;
    logic       run;
    logic       live;
  } mode_t;

  // number of buffer pages that may be outstanding at once
  function automatic logic [2:0] slot_limit(input logic [1:0] spare);
    return (spare > 2'd2) ? 3'd2 : (3'd4 - {1'b0, spare});
  endfunction

endpackage

// File: rtl/scl_regs.sv
module scl_regs
  import scl_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int WIDTH_BITS  = 14,
  parameter int X_BITS      = 13,
  parameter int HEIGHT_BITS = 16,
  parameter int PITCH_BITS  = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [2:0]             reg_sel,
  input  logic [31:0]            reg_wdata,
  output mode_t                  mode_q,
  output logic [ADDR_BITS-1:0]   base_q,
  output logic [PITCH_BITS-1:0]  pitch_q,
  output logic [WIDTH_BITS-1:0]  win_w_q,
  output logic [HEIGHT_BITS-1:0] win_h_q,
  output logic [X_BITS-1:0]      org_x_q,
  output logic [HEIGHT_BITS-1:0] org_y_q,
  output logic [X_BITS-1:0]      beg_x_q,
  output logic [HEIGHT_BITS-1:0] beg_y_q
);

  localparam int HI = 16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      base_q  <= '0;
      pitch_q <= '0;
      win_w_q <= '0;
      win_h_q <= '0;
      org_x_q <= '0;
      org_y_q <= '0;
      beg_x_q <= '0;
      beg_y_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_MODE:  mode_q  <= mode_t'(reg_wdata[3:0]);
        SEL_BASE:  base_q  <= reg_wdata[ADDR_BITS-1:0];
        SEL_PITCH: pitch_q <= reg_wdata[PITCH_BITS-1:0];
        SEL_SIZE: begin
          win_w_q <= reg_wdata[WIDTH_BITS-1:0];
          win_h_q <= reg_wdata[HI +: HEIGHT_BITS];
        end
        SEL_ORIGIN: begin
          org_x_q <= reg_wdata[X_BITS-1:0];
          org_y_q <= reg_wdata[HI +: HEIGHT_BITS];
        end
        SEL_START: begin
          beg_x_q <= reg_wdata[X_BITS-1:0];
          beg_y_q <= reg_wdata[HI +: HEIGHT_BITS];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/scl_walker.sv
module scl_walker #(
  parameter int WIDTH_BITS  = 14,
  parameter int X_BITS      = 13,
  parameter int HEIGHT_BITS = 16,
  parameter int XFER_BITS   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   load,
  input  logic                   step,
  input  logic [WIDTH_BITS:0]    wid_eff,
  input  logic [HEIGHT_BITS:0]   hgt_eff,
  input  logic [X_BITS-1:0]      start_col,
  input  logic [HEIGHT_BITS-1:0] start_row,
  output logic                   active,
  output logic [WIDTH_BITS:0]    col,
  output logic [HEIGHT_BITS:0]   row,
  output logic [XFER_BITS:0]     chunk,
  output logic                   line_end,
  output logic                   frame_end
);

  localparam int CW = WIDTH_BITS + 1;
  localparam int RW = HEIGHT_BITS + 1;
  localparam logic [CW-1:0] PAGE = CW'(1) << XFER_BITS;

  logic [CW-1:0] remain;

  always_comb begin
    remain    = wid_eff - col;
    line_end  = (remain <= PAGE);
    chunk     = line_end ? remain[XFER_BITS:0] : PAGE[XFER_BITS:0];
    frame_end = line_end && ((row + RW'(1)) == hgt_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      active <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else if (load) begin
      active <= 1'b1;
      col    <= CW'(start_col);
      row    <= RW'(start_row);
    end else if (step && active) begin
      if (line_end) begin
        col <= '0;
        row <= row + RW'(1);
        if (frame_end) active <= 1'b0;
      end else begin
        col <= col + PAGE;
      end
    end
  end

endmodule

// File: rtl/scl_pager.sv
module scl_pager (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic       step,
  input  logic       release_pg,
  input  logic [2:0] limit,
  output logic [2:0] out_cnt,
  output logic       room,
  output logic [3:0] issued
);

  logic dec;

  assign dec  = release_pg && ((out_cnt != 3'd0) || step);
  assign room = (out_cnt < limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || load) begin
      out_cnt <= '0;
      issued  <= '0;
    end else begin
      out_cnt <= out_cnt + {2'b00, step} - {2'b00, dec};
      issued  <= issued + {3'b000, step};
    end
  end

endmodule

// File: rtl/scl_seq.sv
module scl_seq
  import scl_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int WIDTH_BITS  = 14,
  parameter int X_BITS      = 13,
  parameter int HEIGHT_BITS = 16,
  parameter int PITCH_BITS  = 13,
  parameter int XFER_BITS   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  input  logic                 frame_start,
  input  logic                 page_release,
  output logic                 xfer_req,
  input  logic                 xfer_ack,
  output logic [ADDR_BITS-1:0] xfer_addr,
  output logic [XFER_BITS:0]   xfer_len,
  output logic [1:0]           xfer_page,
  output logic [31:0]          status
);

  localparam int CW = WIDTH_BITS + 1;
  localparam int RW = HEIGHT_BITS + 1;

  function automatic logic [CW-1:0] width_span(input logic [WIDTH_BITS-1:0] f);
    return (f == '0) ? (CW'(1) << WIDTH_BITS) : CW'(f);
  endfunction

  function automatic logic [RW-1:0] height_span(input logic [HEIGHT_BITS-1:0] f);
    return (f == '0) ? (RW'(1) << HEIGHT_BITS) : RW'(f);
  endfunction

  function automatic logic [ADDR_BITS-1:0] cell_addr(input logic [ADDR_BITS-1:0]  b,
                                                     input logic [PITCH_BITS-1:0] p,
                                                     input logic [RW-1:0]         r,
                                                     input logic [CW-1:0]         c);
    return b + ADDR_BITS'(r) * ADDR_BITS'(p) + ADDR_BITS'(c);
  endfunction

  mode_t                  mode_q;
  logic [ADDR_BITS-1:0]   base_q;
  logic [PITCH_BITS-1:0]  pitch_q;
  logic [WIDTH_BITS-1:0]  win_w_q;
  logic [HEIGHT_BITS-1:0] win_h_q;
  logic [X_BITS-1:0]      org_x_q;
  logic [HEIGHT_BITS-1:0] org_y_q;
  logic [X_BITS-1:0]      beg_x_q;
  logic [HEIGHT_BITS-1:0] beg_y_q;

  // named internal events
  logic          seq_clear;
  logic          seq_load;
  logic          seq_issue;
  logic          walk_active;
  logic          line_end;
  logic          frame_end;
  logic          room;
  logic [2:0]    out_cnt;
  logic [2:0]    out_limit;
  logic [3:0]    issued;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [CW-1:0] wid_eff;
  logic [RW-1:0] hgt_eff;
  logic          done_q;

  scl_regs #(
    .ADDR_BITS(ADDR_BITS), .WIDTH_BITS(WIDTH_BITS), .X_BITS(X_BITS),
    .HEIGHT_BITS(HEIGHT_BITS), .PITCH_BITS(PITCH_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mode_q(mode_q), .base_q(base_q), .pitch_q(pitch_q), .win_w_q(win_w_q),
    .win_h_q(win_h_q), .org_x_q(org_x_q), .org_y_q(org_y_q),
    .beg_x_q(beg_x_q), .beg_y_q(beg_y_q)
  );

  assign wid_eff   = width_span(win_w_q);
  assign hgt_eff   = height_span(win_h_q);
  assign out_limit = slot_limit(mode_q.spare_pg);
  assign seq_clear = !mode_q.live;
  assign seq_load  = frame_start && mode_q.live && mode_q.run;
  assign xfer_req  = walk_active && mode_q.live && mode_q.run && room;
  assign seq_issue = xfer_req && xfer_ack;

  scl_walker #(
    .WIDTH_BITS(WIDTH_BITS), .X_BITS(X_BITS), .HEIGHT_BITS(HEIGHT_BITS), .XFER_BITS(XFER_BITS)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .clear(seq_clear), .load(seq_load), .step(seq_issue),
    .wid_eff(wid_eff), .hgt_eff(hgt_eff), .start_col(beg_x_q), .start_row(beg_y_q),
    .active(walk_active), .col(col), .row(row), .chunk(xfer_len),
    .line_end(line_end), .frame_end(frame_end)
  );

  scl_pager u_pager (
    .clk(clk), .rst_n(rst_n), .clear(seq_clear), .load(seq_load), .step(seq_issue),
    .release_pg(page_release), .limit(out_limit), .out_cnt(out_cnt), .room(room),
    .issued(issued)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || seq_clear || seq_load) done_q <= 1'b0;
    else if (seq_issue && frame_end)     done_q <= 1'b1;
  end

  assign xfer_addr = cell_addr(base_q, pitch_q, RW'(org_y_q) + row, CW'(org_x_q) + col);
  assign xfer_page = issued[1:0];
  assign status    = {6'd0, done_q, walk_active, 4'd0, issued, 16'd0};

endmodule

// File: rtl/scl_seq_chk.sv
module scl_seq_chk #(
  parameter int XFER_BITS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xfer_req,
  input logic               xfer_ack,
  input logic               frame_start,
  input logic               reg_we,
  input logic [XFER_BITS:0] xfer_len,
  input logic [1:0]         xfer_page,
  input logic [31:0]        status,
  input logic [2:0]         out_cnt,
  input logic [2:0]         out_limit,
  input logic               run_on,
  input logic               live_on
);

  localparam logic [XFER_BITS:0] PAGE = (XFER_BITS+1)'(1) << XFER_BITS;

  // R8
  pages_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !reg_we) |=> (out_cnt <= out_limit));

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len != '0 && xfer_len <= PAGE));

  // R12
  paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_on |-> !xfer_req);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[24] && status[25]));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[25]) |-> ($past(frame_start) || !$past(live_on)));

  // R7
  page_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack && !frame_start && live_on && !reg_we)
      |=> (xfer_page == $past(xfer_page) + 2'd1));

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live_on |=> (status == 32'd0 && !xfer_req));

endmodule

bind scl_seq scl_seq_chk #(.XFER_BITS(XFER_BITS)) u_scl_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .frame_start(frame_start), .reg_we(reg_we), .xfer_len(xfer_len),
  .xfer_page(xfer_page), .status(status), .out_cnt(out_cnt), .out_limit(out_limit),
  .run_on(mode_q.run), .live_on(mode_q.live)
);

// File: tb/test_scl_seq.sv
module test_scl_seq;

  localparam int XB = 2;
  localparam int PG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        page_release = 1'b0;
  logic        xfer_req;
  logic        xfer_ack = 1'b0;
  logic [23:0] xfer_addr;
  logic [XB:0] xfer_len;
  logic [1:0]  xfer_page;
  logic [31:0] status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scl_seq #(.XFER_BITS(XB)) i_scl_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_start(frame_start), .page_release(page_release), .xfer_req(xfer_req),
    .xfer_ack(xfer_ack), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_page(xfer_page), .status(status)
  );

  task automatic chk_eq(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint exp_addr(input longint b, p, y0, y, x0, x);
    return (b + (y0 + y) * p + x0 + x) % 64'h1000000;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_mode(input int extra, input bit run, input bit live);
    wr(3'd0, 32'((extra << 2) | (int'(run) << 1) | int'(live)));
  endtask

  task automatic pulse_start();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic program_win(input int b, p, w, h, x0, y0, sx, sy);
    wr(3'd1, 32'(b));
    wr(3'd2, 32'(p));
    wr(3'd3, 32'(((h & 16'hffff) << 16) | w));
    wr(3'd4, 32'((y0 << 16) | x0));
    wr(3'd5, 32'((sy << 16) | sx));
  endtask

  // wait for a request, compare it, accept it (optionally releasing a page too)
  task automatic serve(input longint ea, input int el, input int ep, input bit rel, input string tag);
    int k = 0;
    while (!xfer_req && k < 40) begin @(negedge clk); k++; end
    total++;
    if (!xfer_req) begin
      bad++;
      $display("FAIL %s: request actual=0 expected=1 (addr %0h)", tag, ea);
    end else begin
      if (longint'(xfer_addr) != ea || int'(xfer_len) != el || int'(xfer_page) != ep) begin
        bad++;
        $display("FAIL %s: actual addr=%0h len=%0d page=%0d expected addr=%0h len=%0d page=%0d",
                 tag, xfer_addr, xfer_len, xfer_page, ea, el, ep);
      end
      xfer_ack = 1'b1; page_release = rel;
      @(negedge clk);
      xfer_ack = 1'b0; page_release = 1'b0;
    end
  endtask

  task automatic run_frame(input int b, p, w, h, x0, y0, sx, sy, input string tag);
    int we = (w == 0) ? 16384 : w;
    int n = 0;
    program_win(b, p, w, h, x0, y0, sx, sy);
    pulse_start();
    for (int y = sy; y < h; y++) begin
      for (int x = (y == sy) ? sx : 0; x < we; x += PG) begin
        int len = (we - x > PG) ? PG : we - x;
        if (y == h - 1 && x + PG >= we)
          chk_eq({tag, " R10 done before last"}, status[25], 0);
        serve(exp_addr(b, p, y0, y, x0, x), len, n % 4, 1'b1, tag);
        n++;
      end
    end
    chk_eq({tag, " R10 done"}, status[25], 1);
    chk_eq({tag, " R9 busy"}, status[24], 0);
    chk_eq({tag, " R9 count"}, (status >> 16) & 32'hf, n % 16);
    chk_eq({tag, " R9 spare bits"}, status & 32'hfcf0ffff, 0);
    chk_eq({tag, " R10 no request"}, xfer_req, 0);
  endtask

  // count accepted requests over a window of cycles, releasing nothing
  task automatic count_grants(input int cycles, output int got);
    got = 0;
    for (int c = 0; c < cycles; c++) begin
      if (xfer_req) begin
        got++;
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_eq("R1 request after reset", xfer_req, 0);
    chk_eq("R1 status after reset", status, 0);

    set_mode(0, 1'b1, 1'b1);

    // R2 R3 R6 R7 sweep over widths, heights and start offsets
    for (int w = 1; w <= 9; w++) begin
      for (int h = 1; h <= 3; h++) begin
        run_frame(32'h1000 + w, 20, w, h, 3 * w, h, (w > 4) ? 1 : 0, (h == 3) ? 1 : 0,
                  "R2/R3/R6/R7 sweep");
      end
    end

    // R2 address wraps modulo 2^24
    run_frame(32'hffff00, 13'h1fff, 6, 2, 7, 12'h900, 0, 0, "R2 wrap");

    // R4 zero width means 16384 units
    run_frame(0, 8000, 0, 1, 5, 2, 0, 0, "R4 zero width");

    // R10 done holds, then the next frame start clears it
    run_frame(32'h40, 16, 5, 2, 0, 0, 0, 0, "R10 frame");
    repeat (10) @(negedge clk);
    chk_eq("R10 done holds", status[25], 1);
    pulse_start();
    chk_eq("R10 done cleared by start", status[25], 0);
    chk_eq("R10 busy after restart", status[24], 1);
    set_mode(0, 1'b1, 1'b0);
    @(negedge clk);
    set_mode(0, 1'b1, 1'b1);

    // R5 zero height means 65536 lines
    program_win(32'h200, 3, 1, 0, 2, 4, 0, 0);
    pulse_start();
    for (int y = 0; y < 300; y++)
      serve(exp_addr(32'h200, 3, 4, y, 2, 0), 1, y % 4, 1'b1, "R5 tall window");
    chk_eq("R5 still busy", status[24], 1);
    chk_eq("R5 not done", status[25], 0);
    // R11 soft clear cancels
    set_mode(0, 1'b1, 1'b0);
    @(negedge clk);
    chk_eq("R11 status cleared", status, 0);
    chk_eq("R11 request dropped", xfer_req, 0);
    set_mode(0, 1'b1, 1'b1);

    // R8 pacing for each reserved-page setting
    for (int e = 0; e < 4; e++) begin
      set_mode(e, 1'b1, 1'b1);
      program_win(0, 40, 9, 3, 0, 0, 0, 0);
      pulse_start();
      count_grants(30, got);
      chk_eq($sformatf("R8 outstanding limit extra=%0d", e), got, (e > 2) ? 2 : 4 - e);
      page_release = 1'b1;
      @(negedge clk);
      page_release = 1'b0;
      count_grants(30, got);
      chk_eq($sformatf("R8 one more per release extra=%0d", e), got, 1);
      chk_eq("R9 count while paced", (status >> 16) & 32'hf, ((e > 2) ? 2 : 4 - e) + 1);
      set_mode(e, 1'b1, 1'b0);
      @(negedge clk);
      chk_eq("R11 clear while paced", status, 0);
    end

    // R12 start ignored while disabled
    set_mode(0, 1'b0, 1'b1);
    program_win(32'h80, 10, 9, 2, 1, 1, 0, 0);
    pulse_start();
    repeat (3) @(negedge clk);
    chk_eq("R12 start ignored busy", status[24], 0);
    chk_eq("R12 start ignored request", xfer_req, 0);

    // R12 pause and resume mid-frame
    set_mode(0, 1'b1, 1'b1);
    pulse_start();
    serve(exp_addr(32'h80, 10, 1, 0, 1, 0), 4, 0, 1'b1, "R12 before pause");
    serve(exp_addr(32'h80, 10, 1, 0, 1, 4), 4, 1, 1'b1, "R12 before pause");
    set_mode(0, 1'b0, 1'b1);
    count_grants(10, got);
    chk_eq("R12 paused no requests", got, 0);
    chk_eq("R12 paused still busy", status[24], 1);
    set_mode(0, 1'b1, 1'b1);
    serve(exp_addr(32'h80, 10, 1, 0, 1, 8), 1, 2, 1'b1, "R12 resume");
    serve(exp_addr(32'h80, 10, 1, 1, 1, 0), 4, 3, 1'b1, "R12 resume");
    serve(exp_addr(32'h80, 10, 1, 1, 1, 4), 4, 0, 1'b1, "R12 resume");
    serve(exp_addr(32'h80, 10, 1, 1, 1, 8), 1, 1, 1'b1, "R12 resume");
    chk_eq("R12 frame completes after resume", status[25], 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule